// File: doc/BRIEF.md
# Four-Channel Triggered DMA Controller

The block holds four DMA channels that move data over one shared memory bus. Software programs each channel through a small write port: a source address, a destination address, a word count and a control word. The control word picks when the transfer starts: at once, on a vertical or horizontal blanking pulse, or, on channels 1 and 2 only, on a stream-buffer refill request. It also picks how each address moves after every step, whether the channel re-arms after it finishes, and whether a step moves 16 or 32 bits.

Every step is one bus read followed by one bus write of the same data. Each phase is held until the bus returns ready. When more than one channel has work pending, a fixed-priority arbiter lets the lowest-numbered channel take the next step. The refill mode is meant for feeding a stream buffer. Each request moves four 32-bit words to one fixed destination.

Top module: `dma_ctrl`

## Requirements
- R1: Source addresses are held to 27 bits on channel 0 and to 28 bits on channels 1 to 3. The upper bits are cleared on load and after every step, so an increment that carries out wraps to zero.
- R2: Destination addresses are held to 27 bits on channels 0 to 2 and to 28 bits on channel 3.
- R3: A programmed count of 0 loads the largest count the channel can hold: 16383 steps on channels 0 to 2 (14-bit count) and 65535 on channel 3 (16-bit count).
- R4: Start timing field ctl[1:0] works as follows. 0 starts the transfer on the enable write, 1 waits for a vblank_i pulse, 2 waits for an hblank_i pulse, and 3 is the special mode.
- R5: A blanking pulse has no effect on a channel that already has a transfer in progress. It starts a channel only when the channel is enabled and its timing field matches the pulse.
- R6: On channels 1 and 2, timing 3 with repeat and enable set does not start on the enable write. Each fifo_req_i[ch] pulse then moves exactly 4 words. The width is forced to 32 bits and the destination stays fixed, whatever the programmed adjustment.
- R7: Retriggering a repeating channel reloads its count from the programmed value. It reloads the destination only when the destination adjustment is increment-reload. The source is never reloaded.
- R8: busy_o[ch] clears when the count is exhausted. A non-repeating channel also clears its enable, so later triggers do nothing. A repeating channel stays enabled and waits for its next trigger.
- R9: When several channels are busy, the lowest-numbered one performs every step until it finishes.
- R10: Address adjustment codes: 0 increment, 1 decrement, 2 fixed, 3 increment-reload (taken as increment while stepping, for either address). The step size is 4 bytes when ctl[7] is set and 2 bytes otherwise.
- R11: Each step issues one read (bus_we_o=0) and then one write (bus_we_o=1) carrying the data just read. Each phase holds its request, address and direction until bus_ready_i is seen.
- R12: Register select cfg_sel_i: 0 source, 1 destination, 2 count, 3 control. Control bits: [1:0] timing, [3:2] destination adjustment, [5:4] source adjustment, [6] repeat, [7] 32-bit width, [8] enable.
- R13: The internal source, destination and count are loaded only when the enable bit goes from 0 to 1. Writing control with the enable already set reloads nothing. Writing control with enable 0 drops a transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 2 | Channel addressed by the write |
| cfg_sel_i | input | 2 | Register addressed by the write |
| cfg_wdata_i | input | 32 | Write data |
| hblank_i | input | 1 | Horizontal blanking pulse |
| vblank_i | input | 1 | Vertical blanking pulse |
| fifo_req_i | input | 4 | Per-channel refill request (channels 1 and 2 only) |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 for write phase, 0 for read phase |
| bus_word_o | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| bus_addr_o | output | 32 | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with ready in a read phase |
| bus_ready_i | input | 1 | Access completes in this cycle |
| busy_o | output | 4 | Per-channel transfer-in-progress flags |

## Verification
Two functions can meet in one cycle: a new trigger for a repeating channel, and that channel's own step that is still stalled on the bus. The bench provokes this by letting one step finish and then holding ready low. It fires the matching blanking pulse in that window, then releases the bus. The check is the total number of writes: three, not a reloaded four. A second case has two channels made busy by the same vblank pulse. The write order on the bus must show all of channel 0's steps before any of channel 3's.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

  typedef enum logic [1:0] {ADJ_INC = 2'd0, ADJ_DEC = 2'd1, ADJ_FIX = 2'd2, ADJ_RLD = 2'd3} adj_e;
  typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_SPC = 2'd3} timing_e;
  typedef enum logic [1:0] {REG_SRC = 2'd0, REG_DST = 2'd1, REG_CNT = 2'd2, REG_CTL = 2'd3} reg_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RD = 2'd1, PH_WR = 2'd2} phase_e;

  // control word, msb first: en word rpt sadj dadj tm
  typedef struct packed {
    logic    en;
    logic    word;
    logic    rpt;
    adj_e    sadj;
    adj_e    dadj;
    timing_e tm;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  function automatic int unsigned src_aw(input int unsigned id);
    return (id == 0) ? 27 : 28;
  endfunction

  function automatic int unsigned dst_aw(input int unsigned id);
    return (id == 3) ? 28 : 27;
  endfunction

  function automatic int unsigned cnt_w(input int unsigned id);
    return (id == 3) ? 16 : 14;
  endfunction

  function automatic bit has_fifo(input int unsigned id);
    return (id == 1) || (id == 2);
  endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);

  // lowest index wins: scan high to low, last hit stays
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned SRC_AW   = 27,
  parameter int unsigned DST_AW   = 27,
  parameter int unsigned CNT_W    = 14,
  parameter bit          HAS_FIFO = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          hblank_i,
  input  logic          vblank_i,
  input  logic          fifo_req_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          word_o
);

  localparam logic [AW-1:0]    SRC_MASK = {{(AW - SRC_AW){1'b0}}, {SRC_AW{1'b1}}};
  localparam logic [AW-1:0]    DST_MASK = {{(AW - DST_AW){1'b0}}, {DST_AW{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FIFO_CNT = CNT_W'(4);

  logic [AW-1:0]    prog_src, prog_dst, cur_src, cur_dst;
  logic [CNT_W-1:0] prog_cnt, cur_cnt, reload_cnt;
  ctl_t             ctl, new_ctl;
  logic             busy, fifo_mode, trig;
  logic [AW-1:0]    step_sz;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input adj_e m,
                                        input logic [AW-1:0] sz);
    case (m)
      ADJ_DEC: return a - sz;
      ADJ_FIX: return a;
      default: return a + sz;
    endcase
  endfunction

  assign fifo_mode  = HAS_FIFO && (ctl.tm == TM_SPC);
  assign word_o     = ctl.word | fifo_mode;
  assign step_sz    = word_o ? AW'(4) : AW'(2);
  assign reload_cnt = (prog_cnt == '0) ? CNT_MAX : prog_cnt;
  assign new_ctl    = ctl_t'(wdata_i[CTL_W-1:0]);
  assign trig       = !busy && ctl.en &&
                      (((ctl.tm == TM_VBL) && vblank_i) ||
                       ((ctl.tm == TM_HBL) && hblank_i) ||
                       (fifo_mode && ctl.rpt && fifo_req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_src <= '0;
      prog_dst <= '0;
      prog_cnt <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      cur_cnt  <= '0;
      ctl      <= '0;
      busy     <= 1'b0;
    end else begin
      if (step_i && busy) begin
        cur_src <= adv(cur_src, ctl.sadj, step_sz) & SRC_MASK;
        if (!fifo_mode) cur_dst <= adv(cur_dst, ctl.dadj, step_sz) & DST_MASK;
        cur_cnt <= cur_cnt - CNT_W'(1);
        if (cur_cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          if (!ctl.rpt) ctl.en <= 1'b0;
        end
      end
      if (trig) begin
        busy <= 1'b1;
        if (fifo_mode) cur_cnt <= FIFO_CNT;
        else if (ctl.rpt) begin
          cur_cnt <= reload_cnt;
          if (ctl.dadj == ADJ_RLD) cur_dst <= prog_dst;
        end
      end
      if (wr_i) begin
        case (reg_e'(sel_i))
          REG_SRC: prog_src <= wdata_i & SRC_MASK;
          REG_DST: prog_dst <= wdata_i & DST_MASK;
          REG_CNT: prog_cnt <= wdata_i[CNT_W-1:0];
          default: begin
            ctl <= new_ctl;
            if (new_ctl.en && !ctl.en) begin
              cur_src <= prog_src;
              cur_dst <= prog_dst;
              cur_cnt <= reload_cnt;
              busy    <= (new_ctl.tm == TM_NOW);
            end else if (!new_ctl.en) begin
              busy <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign busy_o = busy;
  assign src_o  = cur_src;
  assign dst_o  = cur_dst;

  a_r13_busy_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ctl.en);
  a_r8_last_step_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy && cur_cnt == CNT_W'(1) && !wr_i) |=> !busy);
  a_r6_fifo_dst_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy && fifo_mode && !wr_i) |=> $stable(cur_dst));
  a_r5_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !step_i && !wr_i) |=> (busy && $stable(cur_cnt)));

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_ctrl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CW-1:0]  cfg_ch_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  input  logic           hblank_i,
  input  logic           vblank_i,
  input  logic [NCH-1:0] fifo_req_i,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic           bus_word_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_ready_i,
  output logic [NCH-1:0] busy_o
);

  phase_e         phase_q;
  logic [CW-1:0]  gidx_q, arb_idx;
  logic [NCH-1:0] arb_gnt, busy, step, word;
  logic [DW-1:0]  data_q;
  logic [AW-1:0]  src [NCH];
  logic [AW-1:0]  dst [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      dma_chan #(
        .AW      (AW),
        .SRC_AW  (src_aw(g)),
        .DST_AW  (dst_aw(g)),
        .CNT_W   (cnt_w(g)),
        .HAS_FIFO(has_fifo(g))
      ) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_we_i && (cfg_ch_i == CW'(g))),
        .sel_i     (cfg_sel_i),
        .wdata_i   (cfg_wdata_i),
        .hblank_i  (hblank_i),
        .vblank_i  (vblank_i),
        .fifo_req_i(fifo_req_i[g]),
        .step_i    (step[g]),
        .busy_o    (busy[g]),
        .src_o     (src[g]),
        .dst_o     (dst[g]),
        .word_o    (word[g])
      );
      assign step[g] = (phase_q == PH_WR) && bus_ready_i && (gidx_q == CW'(g));
    end
  endgenerate

  dma_prio_arb #(.N(NCH), .IW(CW)) u_arb (
    .req_i(busy),
    .gnt_o(arb_gnt),
    .idx_o(arb_idx)
  );

  // grant is latched per step so a late higher-priority trigger cannot split a read from its write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      gidx_q  <= '0;
      data_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (|busy) begin
          gidx_q  <= arb_idx;
          phase_q <= PH_RD;
        end
        PH_RD: if (bus_ready_i) begin
          data_q  <= bus_rdata_i;
          phase_q <= PH_WR;
        end
        PH_WR: if (bus_ready_i) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (phase_q != PH_IDLE);
  assign bus_we_o    = (phase_q == PH_WR);
  assign bus_word_o  = word[gidx_q];
  assign bus_addr_o  = (phase_q == PH_WR) ? dst[gidx_q] : src[gidx_q];
  assign bus_wdata_o = data_q;
  assign busy_o      = busy;

  a_r9_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(arb_gnt) && ((|busy) == (|arb_gnt)));
  a_r9_ch0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy[0] |-> arb_gnt[0]);
  a_r11_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)));
  a_r11_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o && !bus_we_o && bus_ready_i));
  a_r11_wdata_is_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_ready_i) |=> (bus_wdata_o == $past(bus_rdata_i)));

endmodule

// File: tb/tb_dma_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hblank = 1'b0, vblank = 1'b0;
  logic [3:0]  fifo_req = '0;
  logic        bus_req, bus_we, bus_word, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  busy;

  localparam logic [31:0] RKEY = 32'hA5C3_0000;

  int          cyc = 0, tests = 0, fails = 0;
  int          rmode = 1;
  int          wn = 0, seq_err = 0;
  bit          rd_pend = 1'b0;
  logic [31:0] rd_addr_q, rd_data_q;
  logic [31:0] w_src [64];
  logic [31:0] w_dst [64];
  logic        w_word [64];

  always #2 clk = ~clk;

  assign bus_rdata = bus_addr ^ RKEY;
  assign bus_ready = (rmode == 0) || ((rmode == 1) && (cyc % 3 != 1));

  dma_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .hblank_i(hblank),
    .vblank_i(vblank), .fifo_req_i(fifo_req), .bus_req_o(bus_req),
    .bus_we_o(bus_we), .bus_word_o(bus_word), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .busy_o(busy)
  );

  // bus monitor: logs completed writes with the read that fed them
  always @(posedge clk) begin
    if (rst_n && bus_req && bus_ready) begin
      if (!bus_we) begin
        rd_addr_q = bus_addr;
        rd_data_q = bus_rdata;
        rd_pend   = 1'b1;
      end else begin
        if (!rd_pend || bus_wdata != rd_data_q) seq_err++;
        rd_pend = 1'b0;
        if (wn < 64) begin
          w_src[wn]  = rd_addr_q;
          w_dst[wn]  = bus_addr;
          w_word[wn] = bus_word;
        end
        wn++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_v();
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
  endtask

  task automatic pulse_h();
    hblank = 1'b1; @(negedge clk); hblank = 1'b0;
  endtask

  task automatic pulse_f(input int ch);
    fifo_req[ch] = 1'b1; @(negedge clk); fifo_req = '0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 100000 && (busy != 0 || bus_req); i++) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ctl: [8] en [7] word [6] rpt [5:4] sadj [3:2] dadj [1:0] timing
  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic [8:0]  ctl;
    logic [15:0] n;
    logic [31:0] lsrc;
    logic [31:0] ldst;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_2000, 16'd3, 9'h180, 16'd3, 32'h0000_1008, 32'h0000_2008},
    '{2'd1, 32'h0000_3000, 32'h0000_4000, 16'd4, 9'h118, 16'd4, 32'h0000_2FFA, 32'h0000_4000},
    '{2'd2, 32'hFFFF_FFF0, 32'hFFFF_FF00, 16'd2, 9'h180, 16'd2, 32'h0FFF_FFF4, 32'h07FF_FF04},
    '{2'd3, 32'hFFFF_0000, 32'hF800_0010, 16'd1, 9'h104, 16'd1, 32'h0FFF_0000, 32'h0800_0010},
    '{2'd0, 32'hFFFF_FFFC, 32'h0000_0100, 16'd2, 9'h18C, 16'd2, 32'h0000_0000, 32'h0000_0104},
    '{2'd3, 32'h0000_0500, 32'h0000_0600, 16'd5, 9'h1A0, 16'd5, 32'h0000_0500, 32'h0000_0610}
  };

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "reset busy", {28'd0, busy}, 32'd0);
    chk("R11", "reset bus_req", {31'd0, bus_req}, 32'd0);

    // table walk: immediate-start transfers, masks, adjust modes, widths
    for (int v = 0; v < NV; v++) begin
      wn = 0;
      wr(VECS[v].ch, 0, VECS[v].src);
      wr(VECS[v].ch, 1, VECS[v].dst);
      wr(VECS[v].ch, 2, {16'd0, VECS[v].cnt});
      wr(VECS[v].ch, 3, {23'd0, VECS[v].ctl});
      wait_idle();
      chk("R4/R12", $sformatf("vec%0d writes", v), wn, {16'd0, VECS[v].n});
      chk("R1/R10", $sformatf("vec%0d last src", v), w_src[wn-1], VECS[v].lsrc);
      chk("R2/R10", $sformatf("vec%0d last dst", v), w_dst[wn-1], VECS[v].ldst);
      chk("R10", $sformatf("vec%0d width", v), {31'd0, w_word[0]}, {31'd0, VECS[v].ctl[7]});
    end

    // R4/R5/R8: vblank timing on ch1, disabled ch3 with matching timing
    wn = 0;
    wr(1, 0, 32'h1000); wr(1, 1, 32'h2000); wr(1, 2, 32'd2);
    wr(3, 3, 32'h001);
    wr(1, 3, 32'h181);
    idle_cycles(3);
    chk("R4", "vblank ch waits", {28'd0, busy}, 32'd0);
    pulse_h();
    idle_cycles(2);
    chk("R5", "hblank mismatch ignored", {28'd0, busy}, 32'd0);
    pulse_v();
    chk("R5", "vblank starts only enabled ch", {28'd0, busy}, 32'b0010);
    wait_idle();
    chk("R4", "vblank transfer writes", wn, 32'd2);
    pulse_v();
    idle_cycles(3);
    chk("R8", "non-repeat enable dropped", wn, 32'd2);

    // R5/R7/R8: repeat with increment-reload on ch2, pulse during stalled step
    wn = 0;
    wr(2, 0, 32'h100); wr(2, 1, 32'h200); wr(2, 2, 32'd3);
    wr(2, 3, 32'h1CE);
    pulse_h();
    for (int i = 0; i < 200 && wn < 1; i++) @(negedge clk);
    rmode = 2;
    idle_cycles(2);
    pulse_h();
    idle_cycles(2);
    rmode = 1;
    wait_idle();
    chk("R5", "pulse during transfer ignored", wn, 32'd3);
    chk("R10", "ch2 third dst", w_dst[2], 32'h208);
    idle_cycles(4);
    chk("R8", "repeat waits for trigger", wn, 32'd3);
    wn = 0;
    pulse_h();
    wait_idle();
    chk("R7", "repeat count reloaded", wn, 32'd3);
    chk("R7", "dst reloaded in inc-reload", w_dst[0], 32'h200);
    chk("R7", "src not reloaded", w_src[0], 32'h10C);

    // R7: plain increment keeps dst running
    wr(2, 3, 32'h000);
    wr(2, 3, 32'h1C2);
    wn = 0;
    pulse_h();
    wait_idle();
    wn = 0;
    pulse_h();
    wait_idle();
    chk("R7", "dst not reloaded in increment", w_dst[0], 32'h20C);
    chk("R7", "count reloaded (increment)", wn, 32'd3);

    // R6: refill mode on ch1
    wn = 0;
    wr(1, 0, 32'h800); wr(1, 1, 32'h40); wr(1, 2, 32'd10);
    wr(1, 3, 32'h143);
    idle_cycles(3);
    chk("R6", "special mode no immediate start", {28'd0, busy}, 32'd0);
    pulse_f(0);
    idle_cycles(2);
    chk("R6", "refill req on ch0 ignored", {28'd0, busy}, 32'd0);
    pulse_f(1);
    wait_idle();
    chk("R6", "refill writes", wn, 32'd4);
    chk("R6", "refill dst fixed", w_dst[3], 32'h40);
    chk("R6", "refill src stride", w_src[3], 32'h80C);
    chk("R6", "refill forced word", {31'd0, w_word[0]}, 32'd1);
    wr(1, 3, 32'h000);

    // R3: zero count on ch0 runs 16383 steps
    rmode = 0;
    wn = 0;
    wr(0, 0, 32'h10); wr(0, 1, 32'h20); wr(0, 2, 32'd0);
    wr(0, 3, 32'h128);
    wait_idle();
    chk("R3", "zero count means max", wn, 32'd16383);
    rmode = 1;

    // R9: ch0 and ch3 triggered by the same pulse
    wn = 0;
    wr(3, 0, 32'h3000); wr(3, 1, 32'h3100); wr(3, 2, 32'd2); wr(3, 3, 32'h181);
    wr(0, 0, 32'h0);    wr(0, 1, 32'h0100); wr(0, 2, 32'd2); wr(0, 3, 32'h181);
    pulse_v();
    chk("R9", "both busy", {28'd0, busy}, 32'b1001);
    wait_idle();
    chk("R9", "total writes", wn, 32'd4);
    chk("R9", "write0 from ch0", w_dst[0], 32'h100);
    chk("R9", "write1 from ch0", w_dst[1], 32'h104);
    chk("R9", "write2 from ch3", w_dst[2], 32'h3100);
    chk("R9", "write3 from ch3", w_dst[3], 32'h3104);

    // R13: no reload without enable edge; disable aborts
    wr(0, 0, 32'h400); wr(0, 1, 32'h500); wr(0, 2, 32'd1); wr(0, 3, 32'h181);
    wr(0, 0, 32'h900); wr(0, 3, 32'h181);
    wn = 0;
    pulse_v();
    wait_idle();
    chk("R13", "no reload while enabled", w_src[0], 32'h400);
    wr(0, 0, 32'h600); wr(0, 3, 32'h181);
    rmode = 2;
    pulse_v();
    chk("R13", "busy before abort", {31'd0, busy[0]}, 32'd1);
    wr(0, 3, 32'h081);
    chk("R13", "disable aborts", {31'd0, busy[0]}, 32'd0);
    rmode = 0;
    wait_idle();
    chk("R11", "read-then-write pairing", seq_err, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule